// File: doc/BRIEF.md
# Receive Character FIFO with Per-Character Error Status

This block is the receive buffer between a serial receive shifter and the CPU. It holds up to two completed characters, each up to nine bits wide. Each character is kept with its own framing-error and parity-error status, so the status the CPU sees always belongs to the character at the head. The shifter hands over a finished character with a one-cycle strobe, and it signals each new start bit with a second strobe. The block trims the character to the configured size and works out its error bits as the character arrives.

The CPU sees the head character's low byte, its ninth bit, its three status flags and a receive-complete flag. A read strobe on the data location removes the head. So the ninth bit and the flags must be taken before the low byte. If both entries are full and a third character is already waiting in the shifter, the next start bit is an overrun. The waiting character is dropped, and the character that becomes visible after the next read carries the overrun flag. Clearing the receiver enable empties everything.

Top module: `rxfifo_top`

## Requirements
- R1: `rxComplete` is 1 while at least one unread character is held and 0 when the buffer is empty. At most two characters are held, plus one character waiting in the shifter.
- R2: A `cpuRead` pulse removes the head character, and the next character becomes visible one cycle later. A `cpuRead` while the buffer is empty changes nothing.
- R3: `sizeCode` sets the character length: 0→5, 1→6, 2→7, 3→8, 7→9 bits, and 4–6 are taken as 8 bits. Data bits above the length read as 0, and `rdBit8` is bit 8 of the stored character.
- R4: `frameErr` is 1 when the head character was delivered with `rxStop` = 0. It describes only the head character.
- R5: `parityErr` of the head character is 1 only if `parityEn` was 1 when the character arrived and the parity check failed. The check counts the ones in the trimmed data plus `rxParity`. With `parityOdd` = 0 an odd count is an error; with `parityOdd` = 1 an even count is an error.
- R6: `startDetect` while two characters are held, a third is waiting and no read takes place is an overrun. The waiting character is dropped and the held pair is kept. `overrun` reads 1 for the character that becomes head after the next read.
- R7: A waiting character moves into the buffer in the same cycle that a read frees a place. A `startDetect` in that same cycle is therefore not an overrun.
- R8: A new character and a read in the same cycle with one character held leave one character held, and the new one becomes the head.
- R9: While `rxEnable` is 0, the buffer and the waiting character are emptied, arriving characters are ignored, and all flags read 0.
- R10: While the buffer is empty, `rdData`, `rdBit8`, `frameErr`, `parityErr` and `overrun` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxEnable | input | 1 | Receiver enable; 0 flushes the block |
| sizeCode | input | 3 | Character length code |
| parityEn | input | 1 | Parity checking enabled |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even parity |
| charDone | input | 1 | One-cycle strobe: the shifter finished a character |
| charData | input | 9 | Raw character bits from the shifter |
| rxParity | input | 1 | Received parity bit |
| rxStop | input | 1 | Sampled first stop bit |
| startDetect | input | 1 | One-cycle strobe: a new start bit was seen |
| cpuRead | input | 1 | One-cycle strobe: CPU read of the data location |
| rdData | output | 8 | Head character, low byte |
| rdBit8 | output | 1 | Head character, ninth bit |
| frameErr | output | 1 | Head character framing error |
| parityErr | output | 1 | Head character parity error |
| overrun | output | 1 | Overrun flag attached to the head character |
| rxComplete | output | 1 | Unread data present |

## Verification
The case that decides the design is a CPU read that lands in the same cycle as a new start bit while both entries are full and a third character waits. The read frees a place, so the waiting character must move in and no overrun may be flagged. The bench provokes this directly after filling the buffer and the shifter slot. It then judges the result by draining: the second character must come out clean, followed by the third, and no flag may be set on either. A second collision, a new character arriving together with a read of the only held character, is judged by seeing the new character as head with the buffer still holding one entry.

// File: rtl/rxfifo_pkg.sv
package rxfifo_pkg;
  localparam int CHAR_W     = 9;
  localparam int FIFO_DEPTH = 2;
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
  localparam int IDX_W      = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int OVR_SLOT   = 1;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              frameErr;
    logic              parityErr;
    logic              overrun;
  } rxEntry_t;

  typedef struct packed {
    logic             shift;
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    logic             wrFromWait;
    logic             loadWait;
    logic             clrWait;
    logic             markOvr;
    logic             flush;
  } rxStrobes_t;
endpackage

// File: rtl/rxfifo_ctrl.sv
module rxfifo_ctrl
  import rxfifo_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxEnable,
  input  logic       charDone,
  input  logic       startDetect,
  input  logic       cpuRead,
  output rxStrobes_t strobes,
  output logic       notEmpty
);
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] afterPop;
  logic [CNT_W-1:0] countNext;
  logic             waitValid;
  logic             popOk;
  logic             space;

  always_comb begin
    popOk    = cpuRead && (count != '0);
    afterPop = count - CNT_W'(popOk);
    space    = afterPop < CNT_W'(FIFO_DEPTH);
    strobes  = '0;
    if (!rxEnable) begin
      strobes.flush = 1'b1;
    end else begin
      strobes.shift = popOk;
      strobes.wrIdx = afterPop[IDX_W-1:0];
      if (waitValid && space) begin
        // freed place is filled from the shifter slot first
        strobes.wrEn       = 1'b1;
        strobes.wrFromWait = 1'b1;
        strobes.clrWait    = 1'b1;
        strobes.loadWait   = charDone;
      end else if (charDone && space) begin
        strobes.wrEn = 1'b1;
      end else if (charDone) begin
        strobes.loadWait = 1'b1;
      end else if (waitValid && startDetect) begin
        strobes.markOvr = 1'b1;
        strobes.clrWait = 1'b1;
      end
    end
    countNext = strobes.flush ? '0 : afterPop + CNT_W'(strobes.wrEn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      waitValid <= 1'b0;
    end else begin
      count <= countNext;
      if (strobes.flush)         waitValid <= 1'b0;
      else if (strobes.loadWait) waitValid <= 1'b1;
      else if (strobes.clrWait)  waitValid <= 1'b0;
    end
  end

  assign notEmpty = (count != '0);

  // R1: occupancy never exceeds the depth
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(FIFO_DEPTH));

  // R1: a character waits in the shifter only behind a full buffer
  a_r1_wait_only_full: assert property (@(posedge clk) disable iff (!rstN)
    waitValid |-> count == CNT_W'(FIFO_DEPTH));

  // R6: overrun is only raised with the buffer full
  a_r6_ovr_needs_full: assert property (@(posedge clk) disable iff (!rstN)
    strobes.markOvr |-> (count == CNT_W'(FIFO_DEPTH) && waitValid && startDetect));

  // R7: a read in the same cycle prevents an overrun
  a_r7_read_blocks_ovr: assert property (@(posedge clk) disable iff (!rstN)
    cpuRead |-> !strobes.markOvr);

  // R8: push and pop together on a single entry keep one entry
  a_r8_push_pop_one: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && count == CNT_W'(1) && cpuRead && charDone && !waitValid)
      |=> count == CNT_W'(1));

  // R9: disable empties the buffer and the shifter slot
  a_r9_flush: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (count == '0 && !waitValid));
endmodule

// File: rtl/rxfifo_datapath.sv
module rxfifo_datapath
  import rxfifo_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobes_t        strobes,
  input  logic [2:0]        sizeCode,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic [CHAR_W-1:0] charData,
  input  logic              rxParity,
  input  logic              rxStop,
  output rxEntry_t          head
);
  rxEntry_t          slot     [FIFO_DEPTH];
  rxEntry_t          slotNext [FIFO_DEPTH];
  rxEntry_t          waitEntry;
  rxEntry_t          incoming;
  logic [3:0]        nBits;
  logic [CHAR_W:0]   wideMask;
  logic [CHAR_W-1:0] trimmed;

  // character length decode and trimming
  always_comb begin
    case (sizeCode)
      3'd0:    nBits = 4'd5;
      3'd1:    nBits = 4'd6;
      3'd2:    nBits = 4'd7;
      3'd7:    nBits = 4'd9;
      default: nBits = 4'd8;
    endcase
    wideMask = ((CHAR_W+1)'(1) << nBits) - (CHAR_W+1)'(1);
    trimmed  = charData & wideMask[CHAR_W-1:0];
    incoming.data      = trimmed;
    incoming.frameErr  = !rxStop;
    incoming.parityErr = parityEn & (^trimmed ^ rxParity ^ parityOdd);
    incoming.overrun   = 1'b0;
  end

  // slot 0 is always the head; a pop shifts every entry down by one
  for (genvar i = 0; i < FIFO_DEPTH; i++) begin : g_slot
    always_comb begin
      if (!strobes.shift)            slotNext[i] = slot[i];
      else if (i + 1 < FIFO_DEPTH)   slotNext[i] = slot[(i + 1) % FIFO_DEPTH];
      else                           slotNext[i] = '0;
      if (strobes.wrEn && strobes.wrIdx == IDX_W'(i))
        slotNext[i] = strobes.wrFromWait ? waitEntry : incoming;
      if (strobes.markOvr && i == OVR_SLOT)
        slotNext[i].overrun = 1'b1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              slot[i] <= '0;
      else if (strobes.flush) slot[i] <= '0;
      else                    slot[i] <= slotNext[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 waitEntry <= '0;
    else if (strobes.flush)    waitEntry <= '0;
    else if (strobes.loadWait) waitEntry <= incoming;
    else if (strobes.clrWait)  waitEntry <= '0;
  end

  assign head = slot[0];

  // R2: the head only changes on a pop, a write into it or a flush
  a_r2_head_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.shift && !strobes.flush && !(strobes.wrEn && strobes.wrIdx == '0))
      |=> $stable(head));

  // R6: an overrun tags the entry visible after the next read
  a_r6_ovr_tag: assert property (@(posedge clk) disable iff (!rstN)
    strobes.markOvr |=> slot[OVR_SLOT].overrun);

  // R9: a flush leaves an all-zero head
  a_r9_flush_head: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flush |=> head == '0);
endmodule

// File: rtl/rxfifo_top.sv
module rxfifo_top
  import rxfifo_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxEnable,
  input  logic [2:0] sizeCode,
  input  logic       parityEn,
  input  logic       parityOdd,
  input  logic       charDone,
  input  logic [8:0] charData,
  input  logic       rxParity,
  input  logic       rxStop,
  input  logic       startDetect,
  input  logic       cpuRead,
  output logic [7:0] rdData,
  output logic       rdBit8,
  output logic       frameErr,
  output logic       parityErr,
  output logic       overrun,
  output logic       rxComplete
);
  rxStrobes_t strobes;
  rxEntry_t   head;

  rxfifo_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .rxEnable   (rxEnable),
    .charDone   (charDone),
    .startDetect(startDetect),
    .cpuRead    (cpuRead),
    .strobes    (strobes),
    .notEmpty   (rxComplete)
  );

  rxfifo_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .sizeCode (sizeCode),
    .parityEn (parityEn),
    .parityOdd(parityOdd),
    .charData (charData),
    .rxParity (rxParity),
    .rxStop   (rxStop),
    .head     (head)
  );

  assign rdData    = head.data[7:0];
  assign rdBit8    = head.data[8];
  assign frameErr  = head.frameErr;
  assign parityErr = head.parityErr;
  assign overrun   = head.overrun;

  // R10: an empty buffer presents all-zero data and flags
  a_r10_empty_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rxComplete |-> (rdData == '0 && !rdBit8 && !frameErr && !parityErr && !overrun));
endmodule

// File: tb/rxfifo_top_tb_top.sv
`timescale 1ns/1ps
module rxfifo_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxEnable = 1'b1;
  logic [2:0] sizeCode = 3'd3;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       charDone = 1'b0;
  logic [8:0] charData = '0;
  logic       rxParity = 1'b0;
  logic       rxStop = 1'b1;
  logic       startDetect = 1'b0;
  logic       cpuRead = 1'b0;
  logic [7:0] rdData;
  logic       rdBit8, frameErr, parityErr, overrun, rxComplete;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  rxfifo_top dut_i (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .sizeCode(sizeCode),
    .parityEn(parityEn), .parityOdd(parityOdd), .charDone(charDone),
    .charData(charData), .rxParity(rxParity), .rxStop(rxStop),
    .startDetect(startDetect), .cpuRead(cpuRead), .rdData(rdData),
    .rdBit8(rdBit8), .frameErr(frameErr), .parityErr(parityErr),
    .overrun(overrun), .rxComplete(rxComplete)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // one clock: pulses set before the call are taken at the edge, then cleared
  task automatic tick();
    @(posedge clk);
    #1;
    charDone = 1'b0;
    startDetect = 1'b0;
    cpuRead = 1'b0;
  endtask

  task automatic pushChar(input logic [8:0] d, input logic par, input logic stop);
    charDone = 1'b1;
    charData = d;
    rxParity = par;
    rxStop   = stop;
  endtask

  task automatic checkHead(input string ctx, input logic [8:0] d, input logic fe,
                           input logic pe, input logic ov, input logic rc);
    chk({ctx, " R3 data"}, int'({rdBit8, rdData}), int'(d));
    chk({ctx, " R4 frameErr"}, int'(frameErr), int'(fe));
    chk({ctx, " R5 parityErr"}, int'(parityErr), int'(pe));
    chk({ctx, " R6 overrun"}, int'(overrun), int'(ov));
    chk({ctx, " R1 rxComplete"}, int'(rxComplete), int'(rc));
  endtask

  task automatic checkEmpty(input string ctx);
    checkHead({ctx, " R10 empty"}, 9'd0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checkEmpty("reset");
    rstN = 1'b1;
    tick();
    checkEmpty("after reset");

    // R2: read on empty buffer has no effect
    cpuRead = 1'b1;
    tick();
    checkEmpty("R2 read when empty");

    // R3 R4 R5: sweep sizes, parity modes and data patterns, one char at a time
    for (int code = 0; code < 8; code++) begin
      for (int pm = 0; pm < 3; pm++) begin
        for (int d = 0; d < 512; d += 13) begin
          int nb;
          logic [8:0] expD;
          logic       par, stop, expPe;
          int ones;
          nb = (code < 4) ? code + 5 : (code == 7) ? 9 : 8;
          expD = 9'(d % (1 << nb));
          par  = 1'(d) ^ 1'(d >> 3);
          stop = 1'(d >> 1);
          ones = $countones(expD) + int'(par);
          expPe = (pm != 0) && ((ones % 2) != ((pm == 2) ? 1 : 0));
          sizeCode  = 3'(code);
          parityEn  = (pm != 0);
          parityOdd = (pm == 2);
          pushChar(9'(d), par, stop);
          tick();
          checkHead("sweep", expD, !stop, expPe, 1'b0, 1'b1);
          cpuRead = 1'b1;
          tick();
          checkEmpty("R2 sweep pop");
        end
      end
    end

    sizeCode = 3'd3;
    parityEn = 1'b0;
    parityOdd = 1'b0;

    // R6: overrun with full buffer and waiting character
    pushChar(9'h11, 1'b0, 1'b1); tick();
    pushChar(9'h22, 1'b0, 1'b1); tick();
    pushChar(9'h33, 1'b0, 1'b1); tick();
    checkHead("R1 full", 9'h11, 1'b0, 1'b0, 1'b0, 1'b1);
    startDetect = 1'b1;
    tick();
    checkHead("R6 head kept", 9'h11, 1'b0, 1'b0, 1'b0, 1'b1);
    cpuRead = 1'b1; tick();
    checkHead("R6 flag on next", 9'h22, 1'b0, 1'b0, 1'b1, 1'b1);
    cpuRead = 1'b1; tick();
    checkEmpty("R6 waiting dropped");

    // R7: read and start bit in the same cycle
    pushChar(9'h44, 1'b0, 1'b1); tick();
    pushChar(9'h55, 1'b0, 1'b1); tick();
    pushChar(9'h66, 1'b0, 1'b1); tick();
    cpuRead = 1'b1;
    startDetect = 1'b1;
    tick();
    checkHead("R7 no overrun", 9'h55, 1'b0, 1'b0, 1'b0, 1'b1);
    cpuRead = 1'b1; tick();
    checkHead("R7 waiting moved in", 9'h66, 1'b0, 1'b0, 1'b0, 1'b1);
    cpuRead = 1'b1; tick();
    checkEmpty("R7 drained");

    // R8: push and pop together on a single entry
    pushChar(9'h77, 1'b0, 1'b1); tick();
    pushChar(9'h88, 1'b0, 1'b1);
    cpuRead = 1'b1;
    tick();
    checkHead("R8 new head", 9'h88, 1'b0, 1'b0, 1'b0, 1'b1);
    cpuRead = 1'b1; tick();
    checkEmpty("R8 one entry only");

    // R4: error status follows its own character
    pushChar(9'h0f, 1'b0, 1'b0); tick();
    pushChar(9'hf0, 1'b0, 1'b1); tick();
    checkHead("R4 head bad stop", 9'h0f, 1'b1, 1'b0, 1'b0, 1'b1);
    cpuRead = 1'b1; tick();
    checkHead("R4 next good stop", 9'hf0, 1'b0, 1'b0, 1'b0, 1'b1);
    cpuRead = 1'b1; tick();

    // R9: disable flushes everything and ignores arrivals
    pushChar(9'h01, 1'b0, 1'b0); tick();
    pushChar(9'h02, 1'b0, 1'b1); tick();
    pushChar(9'h03, 1'b0, 1'b1); tick();
    rxEnable = 1'b0;
    tick();
    checkEmpty("R9 flushed");
    pushChar(9'h04, 1'b0, 1'b1); tick();
    checkEmpty("R9 ignored while off");
    rxEnable = 1'b1;
    tick();
    checkEmpty("R9 reenabled empty");
    pushChar(9'h05, 1'b0, 1'b1); tick();
    checkHead("R9 works again", 9'h05, 1'b0, 1'b0, 1'b0, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule